// File: doc/BRIEF.md
# Display Command Queue Scheduler

This block queues command packets that a host writes for a display peripheral and decides when each one goes to the downstream packet builder. Each entry has a 6-bit data type, a 2-bit virtual channel and a 16-bit field. In a short packet the field holds the two parameter bytes. In a long packet it holds the word count. The block does not form the packet bytes. It hands a header (type, channel, field and a long flag) to the builder over a valid/ready stream.

A mode pin selects between two ways of working. In video mode, queued commands go out only while the timing generator reports a blanking interval, and only when the bytes left in that interval can carry the whole packet. In command mode every valid queued command goes out as soon as the builder accepts it. Video traffic that passes through the block is blocked in command mode. An entry with a data type the block does not support is discarded at the head of the queue and sets a sticky interrupt flag.

Both streams follow the usual valid/ready rules. A transfer takes place on a clock edge where valid and ready are both high. Once the block raises valid on the header stream, it holds the header unchanged until ready is seen. The write stream drops `wr_ready` when the queue is full, and a write offered while `wr_ready` is low has no effect.

Top module: `dcq_sched`

## Requirements
- R1: After reset, `hdr_valid` and `irq_badtype` are 0 and `wr_ready` is 1.
- R2: The queue holds 16 entries. With 16 entries stored, `wr_ready` is 0, and a write offered while `wr_ready` is 0 is not stored and never issued.
- R3: Supported commands reach the header port in exactly the order they were written.
- R4: In video mode (`mode_cmd`=0), a header is issued only while `blank_active` is 1.
- R5: The packet length is 4 bytes for a short packet and word count + 6 bytes for a long packet. In video mode, a command is issued only if the bytes already issued in the current blanking interval plus its length do not exceed `blank_budget`. The issued-byte tally restarts at zero whenever `blank_active` is 0.
- R6: A head entry that does not fit stays at the head. No entry behind it is issued until it has been issued.
- R7: In command mode (`mode_cmd`=1), supported short and long commands are issued whatever the value of `blank_active`.
- R8: In command mode, `vid_out_valid` and `vid_in_ready` are 0. In video mode, `vid_out_valid`/`vid_out_data` follow `vid_in_valid`/`vid_in_data`, and `vid_in_ready` follows `vid_out_ready`.
- R9: An unsupported data type at the head is dropped without being issued and sets `irq_badtype`. The flag stays at 1 until a cycle with `irq_clr`=1 and no new drop. The entries behind the dropped one are still issued.
- R10: While `hdr_valid` is 1 and `hdr_ready` is 0, `hdr_valid` stays 1 and the header fields do not change.
- R11: The supported short types are 0x03, 0x13, 0x23, 0x05, 0x15 and 0x37. The supported long types are 0x29 and 0x39, and `hdr_long` is 1 exactly for these. Every other type is unsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cmd | input | 1 | 1 = command mode, 0 = video mode |
| wr_valid | input | 1 | Host command write valid |
| wr_ready | output | 1 | Queue can accept a write |
| wr_dtype | input | 6 | Data type of the written command |
| wr_vc | input | 2 | Virtual channel of the written command |
| wr_field | input | 16 | Parameter bytes (short) or word count (long) |
| blank_active | input | 1 | Timing generator reports a blanking interval |
| blank_budget | input | 16 | Byte capacity of the current blanking interval |
| vid_in_valid | input | 1 | Video stream valid from the upstream source |
| vid_in_data | input | VID_W | Video stream data from the upstream source |
| vid_in_ready | output | 1 | Ready back to the video source |
| vid_out_valid | output | 1 | Video stream valid to the packet builder |
| vid_out_data | output | VID_W | Video stream data to the packet builder |
| vid_out_ready | input | 1 | Packet builder ready for video |
| hdr_valid | output | 1 | Command header valid |
| hdr_ready | input | 1 | Packet builder accepts the header |
| hdr_dtype | output | 6 | Header data type |
| hdr_vc | output | 2 | Header virtual channel |
| hdr_field | output | 16 | Header parameter bytes or word count |
| hdr_long | output | 1 | Header is a long packet |
| irq_badtype | output | 1 | Sticky unsupported-type interrupt flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for the flag |

## Verification
The embedded assertions check on every cycle the rules that do not depend on a scenario:
- the header holds while it is stalled;
- no header starts outside blanking in video mode;
- the queue never pops when empty and counts pushes correctly;
- the interrupt flag is sticky;
- a dropped entry raises the flag;
- command mode issues promptly.

Only the bench scenarios can show that the byte tally refuses a third command in a small slot and restarts in the next slot. The same holds for head-of-line blocking behind a long packet and for FIFO order across a mix of packet types. They also show that a bad entry leaves the order of the others intact and that a write into a full queue is lost.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int DT_W  = 6;
  localparam int VC_W  = 2;
  localparam int FLD_W = 16;
  localparam int LEN_W = FLD_W + 1;

  typedef struct packed {
    logic [DT_W-1:0]  dtype;
    logic [VC_W-1:0]  vc;
    logic [FLD_W-1:0] field;
  } cmd_t;

  typedef struct packed {
    logic             ok;
    logic             is_long;
    logic [LEN_W-1:0] len;
  } cls_t;

  localparam int N_SHORT = 6;
  localparam int N_LONG  = 2;
  localparam logic [N_SHORT*DT_W-1:0] SHORT_SET =
    {6'h03, 6'h13, 6'h23, 6'h05, 6'h15, 6'h37};
  localparam logic [N_LONG*DT_W-1:0] LONG_SET = {6'h29, 6'h39};
endpackage

// File: rtl/dcq_fifo.sv
module dcq_fifo
  import dcq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t din,
  input  logic pop,
  output cmd_t head,
  output logic empty,
  output logic full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  cmd_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R2
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/dcq_classify.sv
module dcq_classify
  import dcq_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int LONG_OVH  = 6
) (
  input  cmd_t head,
  output cls_t cls
);
  logic [N_SHORT-1:0] hit_s;
  logic [N_LONG-1:0]  hit_l;

  for (genvar i = 0; i < N_SHORT; i++) begin : g_short
    assign hit_s[i] = (head.dtype == SHORT_SET[i*DT_W +: DT_W]);
  end
  for (genvar j = 0; j < N_LONG; j++) begin : g_long
    assign hit_l[j] = (head.dtype == LONG_SET[j*DT_W +: DT_W]);
  end

  always_comb begin
    cls.is_long = |hit_l;
    cls.ok      = (|hit_s) || (|hit_l);
    cls.len     = cls.is_long ? ({1'b0, head.field} + LEN_W'(LONG_OVH))
                              : LEN_W'(SHORT_LEN);
  end
endmodule

// File: rtl/dcq_issue.sv
module dcq_issue
  import dcq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cmd,
  input  logic             blank_active,
  input  logic [FLD_W-1:0] blank_budget,
  input  logic             head_vld,
  input  cmd_t             head,
  input  cls_t             cls,
  output logic             pop,
  output logic             hdr_valid,
  input  logic             hdr_ready,
  output cmd_t             hdr,
  output logic             hdr_long,
  input  logic             irq_clr,
  output logic             irq
);
  logic             can_load, fits, ld, drop;
  logic [LEN_W-1:0] used_q;
  logic [LEN_W:0]   need;

  assign need     = {1'b0, used_q} + {1'b0, cls.len};
  assign can_load = !hdr_valid || hdr_ready;
  assign fits     = mode_cmd ||
                    (blank_active && (need <= {2'b00, blank_budget}));
  assign drop     = head_vld && !cls.ok;
  assign ld       = head_vld && cls.ok && can_load && fits;
  assign pop      = drop || ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_valid <= 1'b0;
      hdr       <= '0;
      hdr_long  <= 1'b0;
      used_q    <= '0;
      irq       <= 1'b0;
    end else begin
      if (ld) begin
        hdr_valid <= 1'b1;
        hdr       <= head;
        hdr_long  <= cls.is_long;
      end else if (hdr_ready) begin
        hdr_valid <= 1'b0;
      end
      if (mode_cmd || !blank_active) used_q <= '0;
      else if (ld)                   used_q <= need[LEN_W-1:0];
      if (drop)         irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R10
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr) && $stable(hdr_long)));

  // R4
  vid_blank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_valid) |-> ($past(mode_cmd) || $past(blank_active)));

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> irq);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R7
  cmd_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd && head_vld && cls.ok && !hdr_valid) |=> hdr_valid);
endmodule

// File: rtl/dcq_sched.sv
module dcq_sched
  import dcq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VID_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cmd,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DT_W-1:0]  wr_dtype,
  input  logic [VC_W-1:0]  wr_vc,
  input  logic [FLD_W-1:0] wr_field,
  input  logic             blank_active,
  input  logic [FLD_W-1:0] blank_budget,
  input  logic             vid_in_valid,
  input  logic [VID_W-1:0] vid_in_data,
  output logic             vid_in_ready,
  output logic             vid_out_valid,
  output logic [VID_W-1:0] vid_out_data,
  input  logic             vid_out_ready,
  output logic             hdr_valid,
  input  logic             hdr_ready,
  output logic [DT_W-1:0]  hdr_dtype,
  output logic [VC_W-1:0]  hdr_vc,
  output logic [FLD_W-1:0] hdr_field,
  output logic             hdr_long,
  output logic             irq_badtype,
  input  logic             irq_clr
);
  cmd_t wr_cmd, head, hdr;
  cls_t cls;
  logic empty, full, push, pop;

  assign wr_cmd   = '{dtype: wr_dtype, vc: wr_vc, field: wr_field};
  assign wr_ready = !full;
  assign push     = wr_valid && !full;

  dcq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_cmd), .pop(pop),
    .head(head), .empty(empty), .full(full)
  );

  dcq_classify u_cls (.head(head), .cls(cls));

  dcq_issue u_issue (
    .clk(clk), .rst_n(rst_n), .mode_cmd(mode_cmd),
    .blank_active(blank_active), .blank_budget(blank_budget),
    .head_vld(!empty), .head(head), .cls(cls), .pop(pop),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr(hdr),
    .hdr_long(hdr_long), .irq_clr(irq_clr), .irq(irq_badtype)
  );

  assign hdr_dtype = hdr.dtype;
  assign hdr_vc    = hdr.vc;
  assign hdr_field = hdr.field;

  assign vid_out_valid = vid_in_valid && !mode_cmd;
  assign vid_out_data  = vid_in_data;
  assign vid_in_ready  = vid_out_ready && !mode_cmd;
endmodule

// File: tb/dcq_sched_tb_top.sv
module dcq_sched_tb_top;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mode_cmd = 1'b1, wr_valid = 1'b0, wr_ready;
  logic [5:0]  wr_dtype = '0;
  logic [1:0]  wr_vc = '0;
  logic [15:0] wr_field = '0;
  logic        blank_active = 1'b0;
  logic [15:0] blank_budget = '0;
  logic        vid_in_valid = 1'b0, vid_in_ready, vid_out_valid, vid_out_ready = 1'b0;
  logic [31:0] vid_in_data = '0, vid_out_data;
  logic        hdr_valid, hdr_ready = 1'b1, hdr_long, irq_badtype, irq_clr = 1'b0;
  logic [5:0]  hdr_dtype;
  logic [1:0]  hdr_vc;
  logic [15:0] hdr_field;

  int checks = 0, errors = 0, issued = 0;
  logic [24:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  dcq_sched dut_i (
    .clk(clk), .rst_n(rst_n), .mode_cmd(mode_cmd),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_dtype(wr_dtype),
    .wr_vc(wr_vc), .wr_field(wr_field),
    .blank_active(blank_active), .blank_budget(blank_budget),
    .vid_in_valid(vid_in_valid), .vid_in_data(vid_in_data),
    .vid_in_ready(vid_in_ready), .vid_out_valid(vid_out_valid),
    .vid_out_data(vid_out_data), .vid_out_ready(vid_out_ready),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_dtype(hdr_dtype),
    .hdr_vc(hdr_vc), .hdr_field(hdr_field), .hdr_long(hdr_long),
    .irq_badtype(irq_badtype), .irq_clr(irq_clr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R11 supported type list, computed from the requirement
  function automatic bit is_long_t(input logic [5:0] d);
    return d == 6'h29 || d == 6'h39;
  endfunction
  function automatic bit is_ok_t(input logic [5:0] d);
    return is_long_t(d) || d == 6'h03 || d == 6'h13 || d == 6'h23 ||
           d == 6'h05 || d == 6'h15 || d == 6'h37;
  endfunction

  // scoreboard monitor: R3 order, R11 long flag
  always @(negedge clk) begin
    if (rst_n && hdr_valid && hdr_ready) begin
      issued++;
      if (exp_q.size() == 0) chk(0, "R3 unexpected header", {hdr_long, hdr_dtype, hdr_vc, hdr_field}, 0);
      else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        chk({hdr_long, hdr_dtype, hdr_vc, hdr_field} == e, "R3/R11 header",
            {hdr_long, hdr_dtype, hdr_vc, hdr_field}, e);
      end
    end
  end

  task automatic push(input logic [5:0] d, input logic [1:0] v, input logic [15:0] f);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_dtype = d; wr_vc = v; wr_field = f;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
    end
    if (is_ok_t(d)) exp_q.push_back({is_long_t(d), d, v, f});
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    logic [5:0] sd; logic [1:0] sv; logic [15:0] sf;
    cyc(3); rst_n = 1'b1; #1;
    // R1 reset state
    @(negedge clk);
    chk(hdr_valid == 0, "R1 hdr_valid", hdr_valid, 0);
    chk(irq_badtype == 0, "R1 irq", irq_badtype, 0);
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);

    // R7 command mode, mixed short and long, blanking low
    mode_cmd = 1'b1;
    push(6'h05, 2'd0, 16'h0029);
    push(6'h39, 2'd1, 16'd12);
    push(6'h15, 2'd2, 16'h3A55);
    push(6'h29, 2'd3, 16'd300);
    cyc(12);
    chk(exp_q.size() == 0, "R7 cmd mode drained", exp_q.size(), 0);

    // R8 video gating
    vid_in_valid = 1'b1; vid_in_data = 32'hCAFE_0001; vid_out_ready = 1'b1;
    @(negedge clk);
    chk(vid_out_valid == 0, "R8 cmd blocks video valid", vid_out_valid, 0);
    chk(vid_in_ready == 0, "R8 cmd blocks video ready", vid_in_ready, 0);
    mode_cmd = 1'b0;
    @(negedge clk);
    chk(vid_out_valid == 1, "R8 video passes valid", vid_out_valid, 1);
    chk(vid_out_data == 32'hCAFE_0001, "R8 video data", vid_out_data, 32'hCAFE_0001);
    chk(vid_in_ready == 1, "R8 video passes ready", vid_in_ready, 1);
    vid_in_valid = 1'b0;

    // R4 no issue outside blanking
    base = issued;
    push(6'h05, 2'd0, 16'h0011);
    cyc(10);
    chk(issued == base, "R4 held outside blank", issued, base);
    // R5 short needs 4 bytes
    blank_budget = 16'd3; blank_active = 1'b1;
    cyc(10);
    chk(issued == base, "R5 budget 3 too small", issued, base);
    blank_budget = 16'd4;
    cyc(6);
    chk(issued == base + 1, "R5 budget 4 fits", issued, base + 1);
    blank_active = 1'b0;

    // R5 tally: 8 bytes take two shorts only
    blank_budget = 16'd8; base = issued;
    push(6'h03, 2'd1, 16'h0001);
    push(6'h13, 2'd1, 16'h0002);
    push(6'h23, 2'd1, 16'h0003);
    blank_active = 1'b1;
    cyc(10);
    chk(issued == base + 2, "R5 tally limits slot", issued, base + 2);
    blank_active = 1'b0; cyc(1); blank_active = 1'b1;
    cyc(6);
    chk(issued == base + 3, "R5 tally restarts", issued, base + 3);
    blank_active = 1'b0;

    // R6 head-of-line: long wc=20 needs 26
    base = issued;
    push(6'h39, 2'd2, 16'd20);
    push(6'h15, 2'd2, 16'h0077);
    blank_budget = 16'd10; blank_active = 1'b1;
    cyc(10);
    chk(issued == base, "R6 short waits behind long", issued, base);
    blank_active = 1'b0; blank_budget = 16'd26; cyc(1); blank_active = 1'b1;
    cyc(8);
    chk(issued == base + 1, "R5/R6 long exactly fits", issued, base + 1);
    blank_active = 1'b0; cyc(1); blank_active = 1'b1;
    cyc(6);
    chk(issued == base + 2, "R6 short in next slot", issued, base + 2);
    blank_active = 1'b0;

    // R9 bad type dropped, flag sticky, next entry proceeds
    mode_cmd = 1'b1;
    push(6'h3F, 2'd0, 16'hBAD0);
    push(6'h05, 2'd3, 16'h0042);
    cyc(8);
    chk(irq_badtype == 1, "R9 flag set", irq_badtype, 1);
    chk(exp_q.size() == 0, "R9 entry after bad issued", exp_q.size(), 0);
    cyc(5);
    chk(irq_badtype == 1, "R9 flag sticky", irq_badtype, 1);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    @(negedge clk);
    chk(irq_badtype == 0, "R9 flag cleared", irq_badtype, 0);

    // R2 full queue
    mode_cmd = 1'b0; blank_active = 1'b0; base = issued;
    for (int i = 0; i < 16; i++) push(6'h15, 2'(i), 16'(i));
    @(negedge clk);
    chk(wr_ready == 0, "R2 full drops ready", wr_ready, 0);
    #1; wr_valid = 1'b1; wr_dtype = 6'h05; wr_field = 16'hDEAD;
    cyc(3); wr_valid = 1'b0;
    mode_cmd = 1'b1;
    cyc(50);
    chk(issued == base + 16, "R2 write to full queue lost", issued, base + 16);
    chk(exp_q.size() == 0, "R2 all queued issued", exp_q.size(), 0);

    // R10 hold under back-pressure
    hdr_ready = 1'b0;
    push(6'h29, 2'd1, 16'd5);
    cyc(3);
    sd = hdr_dtype; sv = hdr_vc; sf = hdr_field;
    cyc(5);
    @(negedge clk);
    chk(hdr_valid == 1, "R10 valid held", hdr_valid, 1);
    chk({hdr_dtype, hdr_vc, hdr_field} == {sd, sv, sf}, "R10 fields stable",
        {hdr_dtype, hdr_vc, hdr_field}, {sd, sv, sf});
    hdr_ready = 1'b1;
    cyc(4);
    chk(exp_q.size() == 0, "R10 released", exp_q.size(), 0);

    finish_run();
  end
endmodule